// File: doc/BRIEF.md
# Segment-Aware RAM Access Guard

This block sits between an embedded controller's byte bus and a 24 KB single-port RAM. The RAM occupies bus addresses 0x2000 to 0x7FFF. Two address windows of it hold data: 0x5B00–0x5FFF and 0x7E00–0x7FFF. Every other RAM address holds program code. Each request carries one address. The guard classifies that address as code, data or outside the RAM. It then uses the current operating mode to decide whether the access may reach the RAM.

While the boot mode input is high, firmware is being loaded. In that mode every RAM address may be read and written. While the mode input is low, the system is in normal operation and only the data windows are reachable. Accesses that are refused never reach the RAM side. They produce a one-cycle violation pulse and set a sticky flag, which stays set until a dedicated clear input removes it. Reads complete one clock after the request. A read-valid strobe arrives in the same cycle as the returned byte.

Top module: `ram_write_guard`

## Requirements
- R1: After a synchronous reset, bus_rvalid, viol_pulse and viol_sticky are all low.
- R2: With boot_mode high, any access in 0x2000–0x7FFF is forwarded in the request cycle. Forwarding means ram_en is high, ram_we equals bus_we, ram_addr is bus_addr minus 0x2000, and ram_wdata equals bus_wdata.
- R3: With boot_mode low, reads and writes in 0x5B00–0x5FFF or 0x7E00–0x7FFF are forwarded in the same way as in R2.
- R4: With boot_mode low, a write to a code address (0x2000–0x5AFF or 0x6000–0x7DFF) keeps ram_en and ram_we low, so the stored byte is unchanged when it is later read in boot mode.
- R5: With boot_mode low, a read of a code address is not forwarded and returns 0x00.
- R6: An access outside 0x2000–0x7FFF is never forwarded in either mode, and a read of such an address returns 0x00.
- R7: A read request produces bus_rvalid high exactly one clock later, with bus_rdata valid in that cycle. A write request produces no bus_rvalid.
- R8: Every refused access (R4, R5, R6) raises viol_pulse for exactly the one cycle after the request. Allowed accesses never raise it.
- R9: viol_sticky becomes high in the cycle viol_pulse rises and stays high until viol_clr is sampled high. A violation and a clear in the same cycle leave it high.
- R10: The permit decision uses the boot_mode value sampled in the request cycle. A mode change in the following cycle does not alter that access's outcome.
- R11: With no request present, ram_en and ram_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | 1 = boot (all RAM reachable), 0 = normal (data windows only) |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| viol_clr | input | 1 | Clears viol_sticky |
| viol_pulse | output | 1 | One-cycle pulse for a refused access |
| viol_sticky | output | 1 | Held violation flag |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | RAM byte offset |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one clock after ram_en |

## Verification
The hardest case to reach from the ports is proving that a refused code write left memory untouched. The bench sets up this case on purpose. It fills a code byte in boot mode, attempts an overwrite in normal mode, then switches back to boot mode and reads the byte. A second hard case is a mode change that lands right after the request edge. The bench flips boot_mode in the cycle after a request and checks that the request still gets the outcome of the mode it was issued under. Random traffic is weighted toward addresses one byte either side of each window edge, so that every comparator boundary is exercised in both modes.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  typedef enum logic [1:0] {
    SEG_NONE = 2'd0,
    SEG_CODE = 2'd1,
    SEG_DATA = 2'd2
  } seg_e;
endpackage

// File: rtl/rwg_decode.sv
module rwg_decode
  import rwg_pkg::*;
#(
  parameter int AW = 16,
  parameter int RAW = 15,
  parameter int RAM_BYTES = 24576,
  parameter logic [AW-1:0] RAM_BASE = 16'h2000,
  parameter int NUM_DATA = 2,
  parameter logic [NUM_DATA-1:0][AW-1:0] DATA_LO = {16'h7E00, 16'h5B00},
  parameter logic [NUM_DATA-1:0][AW-1:0] DATA_HI = {16'h7FFF, 16'h5FFF}
) (
  input  logic [AW-1:0]  addr,
  output seg_e           seg,
  output logic [RAW-1:0] offset
);
  localparam logic [AW:0] TOP_EXCL = {1'b0, RAM_BASE} + (AW+1)'(RAM_BYTES);

  logic               in_ram;
  logic [NUM_DATA-1:0] win_hit;
  logic [AW-1:0]      diff;

  assign in_ram = (addr >= RAM_BASE) && ({1'b0, addr} < TOP_EXCL);

  // one comparator pair per data window
  for (genvar g = 0; g < NUM_DATA; g++) begin : g_win
    assign win_hit[g] = (addr >= DATA_LO[g]) && (addr <= DATA_HI[g]);
  end

  always_comb begin
    if (!in_ram)        seg = SEG_NONE;
    else if (|win_hit)  seg = SEG_DATA;
    else                seg = SEG_CODE;
  end

  assign diff   = addr - RAM_BASE;
  assign offset = diff[RAW-1:0];
endmodule

// File: rtl/rwg_policy.sv
module rwg_policy
  import rwg_pkg::*;
(
  input  logic req,
  input  logic we,
  input  logic boot,
  input  seg_e seg,
  output logic fwd,
  output logic fwd_we,
  output logic deny
);
  logic allow;

  always_comb begin
    unique case (seg)
      SEG_DATA: allow = 1'b1;
      SEG_CODE: allow = boot;
      default:  allow = 1'b0;
    endcase
  end

  assign fwd    = req & allow;
  assign fwd_we = req & allow & we;
  assign deny   = req & ~allow;
endmodule

// File: rtl/rwg_resp.sv
module rwg_resp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic          fwd,
  input  logic          deny,
  input  logic          clr,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          viol_pulse,
  output logic          viol_sticky
);
  logic rd_fwd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid      <= 1'b0;
      rd_fwd_q    <= 1'b0;
      viol_pulse  <= 1'b0;
      viol_sticky <= 1'b0;
    end else begin
      rvalid     <= req & ~we;
      rd_fwd_q   <= fwd & ~we;
      viol_pulse <= deny;
      if (deny)     viol_sticky <= 1'b1;
      else if (clr) viol_sticky <= 1'b0;
    end
  end

  // refused or out-of-range reads return zero
  assign rdata = rd_fwd_q ? ram_rdata : '0;
endmodule

// File: rtl/ram_write_guard.sv
module ram_write_guard
  import rwg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RAM_BYTES = 24576,
  parameter logic [AW-1:0] RAM_BASE = 16'h2000,
  parameter int NUM_DATA = 2,
  parameter logic [NUM_DATA-1:0][AW-1:0] DATA_LO = {16'h7E00, 16'h5B00},
  parameter logic [NUM_DATA-1:0][AW-1:0] DATA_HI = {16'h7FFF, 16'h5FFF},
  localparam int RAW = $clog2(RAM_BYTES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           boot_mode,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  input  logic           viol_clr,
  output logic           viol_pulse,
  output logic           viol_sticky,
  output logic           ram_en,
  output logic           ram_we,
  output logic [RAW-1:0] ram_addr,
  output logic [DW-1:0]  ram_wdata,
  input  logic [DW-1:0]  ram_rdata
);
  seg_e seg;
  logic deny;

  rwg_decode #(
    .AW(AW), .RAW(RAW), .RAM_BYTES(RAM_BYTES), .RAM_BASE(RAM_BASE),
    .NUM_DATA(NUM_DATA), .DATA_LO(DATA_LO), .DATA_HI(DATA_HI)
  ) u_dec (
    .addr(bus_addr), .seg(seg), .offset(ram_addr)
  );

  rwg_policy u_pol (
    .req(bus_req), .we(bus_we), .boot(boot_mode), .seg(seg),
    .fwd(ram_en), .fwd_we(ram_we), .deny(deny)
  );

  rwg_resp #(.DW(DW)) u_rsp (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .fwd(ram_en),
    .deny(deny), .clr(viol_clr), .ram_rdata(ram_rdata),
    .rdata(bus_rdata), .rvalid(bus_rvalid),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky)
  );

  assign ram_wdata = bus_wdata;
endmodule

// File: rtl/rwg_checker.sv
module rwg_checker #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RAW = 15,
  parameter logic [AW-1:0] RAM_BASE = 16'h2000
) (
  input logic           clk,
  input logic           rst,
  input logic           boot_mode,
  input logic           bus_req,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic           bus_rvalid,
  input logic           viol_clr,
  input logic           viol_pulse,
  input logic           viol_sticky,
  input logic           ram_en,
  input logic           ram_we,
  input logic [RAW-1:0] ram_addr,
  input logic [DW-1:0]  ram_wdata,
  input logic [DW-1:0]  ram_rdata
);
  logic          chk_in_ram, chk_is_data;
  logic [AW-1:0] chk_diff;

  assign chk_in_ram  = (bus_addr >= 16'h2000) && (bus_addr <= 16'h7FFF);
  assign chk_is_data = ((bus_addr >= 16'h5B00) && (bus_addr <= 16'h5FFF)) ||
                       (bus_addr >= 16'h7E00 && bus_addr <= 16'h7FFF);
  assign chk_diff    = bus_addr - RAM_BASE;

  a_r4_no_code_write: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !boot_mode && chk_in_ram && !chk_is_data) |-> !ram_we);

  a_r6_outside_blocked: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !chk_in_ram) |-> !ram_en);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (!ram_en && !ram_we));

  a_r2_addr_map: assert property (@(posedge clk) disable iff (rst)
    ram_en |-> (ram_addr == chk_diff[RAW-1:0] && ram_wdata == bus_wdata));

  a_r7_read_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  a_r7_no_strobe_on_write: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |=> !bus_rvalid);

  a_r7_data_pass: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && ram_en) |=> (bus_rdata == ram_rdata));

  a_r5_zero_on_refused_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && !ram_en) |=> (bus_rdata == '0));

  a_r8_pulse_after_req: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !ram_en) |=> viol_pulse);

  a_r8_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    (!bus_req || ram_en) |=> !viol_pulse);

  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (viol_sticky && !viol_clr) |=> viol_sticky);

  a_r9_sticky_follows_pulse: assert property (@(posedge clk) disable iff (rst)
    viol_pulse |-> viol_sticky);
endmodule

bind ram_write_guard rwg_checker #(
  .AW(AW), .DW(DW), .RAW(RAW), .RAM_BASE(RAM_BASE)
) u_chk (.*);

// File: tb/ram_write_guard_tb.sv
`timescale 1ns/1ps
module ram_write_guard_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        boot_mode, bus_req, bus_we, viol_clr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, ram_wdata, ram_rdata;
  logic        bus_rvalid, viol_pulse, viol_sticky, ram_en, ram_we;
  logic [14:0] ram_addr;

  int  n_chk = 0;
  int  n_err = 0;
  bit  sticky_exp = 1'b0;
  bit  done = 1'b0;
  logic [7:0] ram_mem [int unsigned];
  logic [7:0] ref_mem [int unsigned];

  always #2.5 clk = ~clk;

  ram_write_guard u_dut (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .viol_clr(viol_clr),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  // behavioural synchronous RAM on the RAM-side port
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[ram_addr] = ram_wdata;
      ram_rdata <= ram_mem.exists(ram_addr) ? ram_mem[ram_addr] : 8'h00;
    end
  end

  function automatic bit in_ram(logic [15:0] a);
    return a >= 16'h2000 && a <= 16'h7FFF;
  endfunction

  function automatic bit in_data(logic [15:0] a);
    return (a >= 16'h5B00 && a <= 16'h5FFF) || (a >= 16'h7E00 && a <= 16'h7FFF);
  endfunction

  function automatic string tag_of(bit boot, bit we, logic [15:0] a);
    if (!in_ram(a)) return "R6";
    if (boot)       return "R2";
    if (in_data(a)) return "R3";
    return we ? "R4" : "R5";
  endfunction

  task automatic chk(bit cond, string req, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one access; entered and left at a falling edge
  task automatic access(bit boot, bit we, logic [15:0] a, logic [7:0] d,
                        bit clr, bit flip);
    bit    ok;
    string t;
    logic [7:0] exp_rd;
    ok = in_ram(a) && (boot || in_data(a));
    t  = flip ? "R10" : tag_of(boot, we, a);
    exp_rd = (ok && ref_mem.exists(a)) ? ref_mem[a] : 8'h00;
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    boot_mode = boot; viol_clr = clr;
    #1;
    chk(ram_en == ok, t, ram_en, ok);
    chk(ram_we == (ok && we), t, ram_we, ok && we);
    if (ok) chk(ram_addr == 15'(a - 16'h2000), "R2", ram_addr, a - 16'h2000);
    @(posedge clk);
    #0.5;
    if (flip) boot_mode = ~boot;
    bus_req = 1'b0; viol_clr = 1'b0;
    @(negedge clk);
    chk(bus_rvalid == !we, "R7", bus_rvalid, !we);
    if (!we) chk(bus_rdata == exp_rd, ok ? "R7" : t, bus_rdata, exp_rd);
    chk(viol_pulse == !ok, flip ? "R10" : "R8", viol_pulse, !ok);
    if (!ok) sticky_exp = 1'b1;
    else if (clr) sticky_exp = 1'b0;
    chk(viol_sticky == sticky_exp, "R9", viol_sticky, sticky_exp);
    if (ok && we) ref_mem[a] = d;
  endtask

  task automatic idle(bit clr);
    bus_req = 1'b0; viol_clr = clr;
    #1;
    chk(!ram_en && !ram_we, "R11", ram_en, 0);
    @(negedge clk);
    viol_clr = 1'b0;
    if (clr) sticky_exp = 1'b0;
    chk(!bus_rvalid && !viol_pulse, "R11", bus_rvalid, 0);
    chk(viol_sticky == sticky_exp, "R9", viol_sticky, sticky_exp);
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] edges [12] = '{16'h1FFF, 16'h2000, 16'h5AFF, 16'h5B00,
      16'h5FFF, 16'h6000, 16'h7DFF, 16'h7E00, 16'h7FFF, 16'h8000,
      16'hFFFF, 16'h0000};
    int k = $urandom_range(0, 9);
    if (k < 3) return edges[$urandom_range(0, 11)];
    if (k < 5) return 16'($urandom_range(16'h5B00, 16'h5FFF));
    if (k < 6) return 16'($urandom_range(16'h7E00, 16'h7FFF));
    if (k < 9) return 16'($urandom_range(16'h2000, 16'h7FFF));
    return 16'($urandom());
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; boot_mode = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; viol_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!bus_rvalid && !viol_pulse && !viol_sticky, "R1", viol_sticky, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: boot-mode writes across code and data edges
    access(1, 1, 16'h2000, 8'hA5, 0, 0);
    access(1, 1, 16'h5AFF, 8'h5A, 0, 0);
    access(1, 1, 16'h6000, 8'h60, 0, 0);
    access(1, 1, 16'h7FFF, 8'h3C, 0, 0);
    access(1, 0, 16'h2000, 8'h00, 0, 0);
    // R3: normal-mode data access
    access(0, 0, 16'h5B00, 8'h00, 0, 0);
    access(0, 1, 16'h5B00, 8'h11, 0, 0);
    access(0, 0, 16'h5B00, 8'h00, 0, 0);
    access(0, 0, 16'h7FFF, 8'h00, 0, 0);
    // R4: refused code write leaves the byte intact
    access(0, 1, 16'h2000, 8'hFF, 0, 0);
    access(1, 0, 16'h2000, 8'h00, 0, 0);
    // R5: normal-mode code read
    access(0, 0, 16'h7DFF, 8'h00, 0, 0);
    access(0, 0, 16'h5AFF, 8'h00, 0, 0);
    // R6: outside the RAM
    access(1, 0, 16'h1FFF, 8'h00, 0, 0);
    access(1, 1, 16'h8000, 8'h77, 0, 0);
    // R9: clear, then violation with a simultaneous clear
    idle(1);
    idle(0);
    access(0, 1, 16'h6000, 8'h99, 1, 0);
    idle(1);
    // R10: mode flips right after the request edge
    access(0, 1, 16'h6000, 8'hEE, 0, 1);
    access(1, 0, 16'h6000, 8'h00, 0, 0);
    access(1, 1, 16'h3000, 8'h42, 0, 1);
    access(0, 0, 16'h5FFF, 8'h00, 0, 1);
    access(1, 0, 16'h3000, 8'h00, 0, 0);

    for (int i = 0; i < 1500; i++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) idle($urandom_range(0, 1) == 1);
      else access($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                  pick_addr(), 8'($urandom()), $urandom_range(0, 7) == 0,
                  $urandom_range(0, 9) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule